// File: doc/BRIEF.md
# Region-Tagged Translation Lookaside Buffer

This block is a small fully associative translation buffer for 64-bit virtual addresses. It uses 4 KiB pages. Each entry is tagged with a 24-bit address-space identifier and a virtual page number. The entry does not record which region it came from.

The block holds eight region registers. The top three bits of a lookup address pick one register, and that register supplies the identifier for the comparison. As a result, one translation can be seen through every region whose register currently holds its identifier. Entries from many address spaces stay resident side by side. Software switches address spaces by rewriting region registers, with no flush.

Region-register writes are staged. They reach lookups only after a serialize strobe.

Insertions arrive on a valid/ready port. The back-pressure rules are:
- `ins_ready` is low in any cycle where a purge is presented.
- While `ins_ready` is low, the producer holds `ins_valid` and its data stable.
- An insert is taken on a clock edge where both `ins_valid` and `ins_ready` are high.

The purge port and the lookup port are plain control pins. A lookup is combinational: its result reflects the state after the previous clock edge.

Top module: `rgn_tag_tlb`

## Requirements
- R1: After reset every entry is invalid and every region register (staged and live) holds identifier 0, so any lookup misses until an insert, and an insert under identifier 0 hits through any region.
- R2: Bits 63:61 of a lookup address select the region register, bits 60:12 form the virtual page number and bits 11:0 the page offset; on a hit `lk_paddr` equals {stored physical page number, offset}.
- R3: An entry matches when it is valid and its stored identifier and page number equal the live identifier of the selected region and the address page number; it hits through every region whose live register holds that identifier, and entries of different identifiers coexist.
- R4: A region-register write only updates a staged copy; a serialize strobe copies all staged values to the live registers at the clock edge, and a write presented in the same cycle as the strobe stays staged and is not yet live.
- R5: Changing a region register never invalidates an entry: restoring an identifier makes its earlier translations hit again.
- R6: An accepted insert whose identifier and page number equal a valid entry rewrites that entry's physical page number instead of creating a second entry.
- R7: An accepted insert without such a match takes the lowest-numbered invalid entry; when all 16 are valid it replaces the entry at a round-robin pointer that starts at 0 after reset and advances by one (wrapping) only on each such replacement.
- R8: A purge clears, at the next edge, every valid entry whose identifier equals `purge_rid`, and leaves entries of other identifiers untouched.
- R9: `ins_ready` equals the inverse of `purge_valid`; an insert presented during a purge is not taken.
- R10: When `lk_valid` is low or no entry matches, `lk_hit` is 0 and `lk_paddr` is 0.
- R11: An insert or purge becomes visible to lookups from the cycle after its accepting edge, not in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rr_wr_en | input | 1 | Write the staged region register |
| rr_wr_idx | input | 3 | Region register index to write |
| rr_wr_rid | input | 24 | Identifier to stage |
| rr_serialize | input | 1 | Copy all staged region registers to live |
| ins_valid | input | 1 | Insert request valid |
| ins_ready | output | 1 | Insert can be accepted this cycle |
| ins_rid | input | 24 | Identifier tag of the inserted translation |
| ins_vpn | input | 49 | Virtual page number of the inserted translation |
| ins_ppn | input | 36 | Physical page number of the inserted translation |
| purge_valid | input | 1 | Purge request |
| purge_rid | input | 24 | Identifier whose entries are cleared |
| lk_valid | input | 1 | Lookup request valid |
| lk_vaddr | input | 64 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_paddr | output | 48 | Translated physical address, zero on miss |

## Verification
A stale live register or a serialize that commits too early shows up on the very next lookup through that region. Such a lookup hits where it should miss, or misses where it should hit.

A wrong allocation or a pointer that drifts stays hidden until the buffer is full. It then evicts the wrong translation. That appears on the first later lookup of the translation that should have survived, or of the one that should have gone.

A purge that leaves a tag behind, or one that clears foreign entries, is seen at the following lookup. Random traffic over few identifiers and pages exercises these cases densely, because overwrite, eviction and purge collide there.

// File: rtl/rgn_tlb_pkg.sv
package rgn_tlb_pkg;
  localparam int VA_W    = 64;
  localparam int RGN_W   = 3;
  localparam int PG_W    = 12;
  localparam int RID_W   = 24;
  localparam int PA_W    = 48;
  localparam int ENTRIES = 16;
endpackage

// File: rtl/rgn_regfile.sv
module rgn_regfile #(
  parameter int RGN_W = rgn_tlb_pkg::RGN_W,
  parameter int RID_W = rgn_tlb_pkg::RID_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [RGN_W-1:0] wr_idx,
  input  logic [RID_W-1:0] wr_rid,
  input  logic             ser,
  input  logic [RGN_W-1:0] rd_idx,
  output logic [RID_W-1:0] rd_rid
);
  localparam int NUM_RGN = 1 << RGN_W;

  logic [NUM_RGN-1:0][RID_W-1:0] stage_q;
  logic [NUM_RGN-1:0][RID_W-1:0] live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      live_q  <= '0;
    end else begin
      if (wr_en) stage_q[wr_idx] <= wr_rid;
      if (ser)   live_q <= stage_q;
    end
  end

  assign rd_rid = live_q[rd_idx];

  // R4: live values move only on a serialize strobe
  a_r4_live_needs_serialize: assert property (@(posedge clk) disable iff (!rst_n)
    !ser |=> $stable(live_q));
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = rgn_tlb_pkg::ENTRIES,
  parameter int RID_W   = rgn_tlb_pkg::RID_W,
  parameter int VPN_W   = 49,
  parameter int PPN_W   = 36,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RID_W-1:0]   lk_rid,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic [ENTRIES-1:0] lk_hit_vec,
  output logic [PPN_W-1:0]   lk_ppn,
  input  logic [RID_W-1:0]   ins_rid,
  input  logic [VPN_W-1:0]   ins_vpn,
  input  logic [PPN_W-1:0]   ins_ppn,
  output logic [ENTRIES-1:0] ins_match_vec,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic               purge_en,
  input  logic [RID_W-1:0]   purge_rid,
  output logic [ENTRIES-1:0] valid_vec
);
  logic [ENTRIES-1:0]             vld_q;
  logic [ENTRIES-1:0][RID_W-1:0]  rid_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rid_q <= '0;
      vpn_q <= '0;
      ppn_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++)
        if (purge_en && vld_q[i] && (rid_q[i] == purge_rid)) vld_q[i] <= 1'b0;
      if (wr_en) begin
        vld_q[wr_idx] <= 1'b1;
        rid_q[wr_idx] <= ins_rid;
        vpn_q[wr_idx] <= ins_vpn;
        ppn_q[wr_idx] <= ins_ppn;
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_hit_vec[g]    = vld_q[g] && (rid_q[g] == lk_rid)  && (vpn_q[g] == lk_vpn);
    assign ins_match_vec[g] = vld_q[g] && (rid_q[g] == ins_rid) && (vpn_q[g] == ins_vpn);
  end

  always_comb begin
    lk_ppn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lk_hit_vec[i]) lk_ppn = lk_ppn | ppn_q[i];
  end

  assign valid_vec = vld_q;

  function automatic logic tag_present(input logic [ENTRIES-1:0] v,
                                       input logic [ENTRIES-1:0][RID_W-1:0] t,
                                       input logic [RID_W-1:0] r);
    logic f;
    f = 1'b0;
    for (int i = 0; i < ENTRIES; i++) if (v[i] && t[i] == r) f = 1'b1;
    return f;
  endfunction

  // R6: no two valid entries share identifier and page
  a_r6_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit_vec) && $onehot0(ins_match_vec));
  // R8: a purged identifier is gone after the edge
  a_r8_purge_clears: assert property (@(posedge clk) disable iff (!rst_n)
    purge_en |=> !tag_present(vld_q, rid_q, $past(purge_rid)));
  // R5: without a purge no entry ever turns invalid
  a_r5_no_silent_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !purge_en |=> (($past(vld_q) & ~vld_q) == '0));
endmodule

// File: rtl/tlb_alloc.sv
module tlb_alloc #(
  parameter int ENTRIES = rgn_tlb_pkg::ENTRIES,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ins_fire,
  input  logic [ENTRIES-1:0] match_vec,
  input  logic [ENTRIES-1:0] valid_vec,
  output logic [IDX_W-1:0]   slot
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] match_idx;
  logic [IDX_W-1:0] free_idx;
  logic             any_match;
  logic             full;

  always_comb begin
    match_idx = '0;
    free_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i])  match_idx = IDX_W'(i);
      if (!valid_vec[i]) free_idx  = IDX_W'(i);
    end
  end

  assign any_match = |match_vec;
  assign full      = &valid_vec;
  assign slot      = any_match ? match_idx : (full ? ptr_q : free_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (ins_fire && !any_match && full)
      ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
  end

  // R7: pointer moves only with an accepted insert
  a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_fire |=> $stable(ptr_q));
  // R7: a fresh insert never lands on a valid entry while a free one exists
  a_r7_fill_free_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_fire && !any_match && !full) |-> !valid_vec[slot]);
endmodule

// File: rtl/rgn_tag_tlb.sv
module rgn_tag_tlb #(
  parameter int VA_W    = rgn_tlb_pkg::VA_W,
  parameter int RGN_W   = rgn_tlb_pkg::RGN_W,
  parameter int PG_W    = rgn_tlb_pkg::PG_W,
  parameter int RID_W   = rgn_tlb_pkg::RID_W,
  parameter int PA_W    = rgn_tlb_pkg::PA_W,
  parameter int ENTRIES = rgn_tlb_pkg::ENTRIES,
  localparam int VPN_W  = VA_W - RGN_W - PG_W,
  localparam int PPN_W  = PA_W - PG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rr_wr_en,
  input  logic [RGN_W-1:0] rr_wr_idx,
  input  logic [RID_W-1:0] rr_wr_rid,
  input  logic             rr_serialize,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic [RID_W-1:0] ins_rid,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic [PPN_W-1:0] ins_ppn,
  input  logic             purge_valid,
  input  logic [RID_W-1:0] purge_rid,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  output logic             lk_hit,
  output logic [PA_W-1:0]  lk_paddr
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [RGN_W-1:0]   lk_rgn;
  logic [VPN_W-1:0]   lk_vpn;
  logic [RID_W-1:0]   lk_rid;
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] valid_vec;
  logic [PPN_W-1:0]   hit_ppn;
  logic [IDX_W-1:0]   slot;
  logic               ins_fire;

  assign lk_rgn    = lk_vaddr[VA_W-1 -: RGN_W];
  assign lk_vpn    = lk_vaddr[VA_W-RGN_W-1:PG_W];
  assign ins_ready = !purge_valid;
  assign ins_fire  = ins_valid && ins_ready;

  rgn_regfile #(.RGN_W(RGN_W), .RID_W(RID_W)) u_rr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(rr_wr_en), .wr_idx(rr_wr_idx), .wr_rid(rr_wr_rid),
    .ser(rr_serialize), .rd_idx(lk_rgn), .rd_rid(lk_rid)
  );

  tlb_cam #(.ENTRIES(ENTRIES), .RID_W(RID_W), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_cam (
    .clk(clk), .rst_n(rst_n),
    .lk_rid(lk_rid), .lk_vpn(lk_vpn), .lk_hit_vec(hit_vec), .lk_ppn(hit_ppn),
    .ins_rid(ins_rid), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn), .ins_match_vec(match_vec),
    .wr_en(ins_fire), .wr_idx(slot),
    .purge_en(purge_valid), .purge_rid(purge_rid),
    .valid_vec(valid_vec)
  );

  tlb_alloc #(.ENTRIES(ENTRIES)) u_alloc (
    .clk(clk), .rst_n(rst_n), .ins_fire(ins_fire),
    .match_vec(match_vec), .valid_vec(valid_vec), .slot(slot)
  );

  assign lk_hit   = lk_valid && (|hit_vec);
  assign lk_paddr = lk_hit ? {hit_ppn, lk_vaddr[PG_W-1:0]} : '0;

  // R10: a miss never leaks an address
  a_r10_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_paddr == '0));
endmodule

// File: tb/rgn_tag_tlb_tb_top.sv
module rgn_tag_tlb_tb_top;
  localparam int NE = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rr_wr_en = 1'b0;
  logic [2:0]  rr_wr_idx = '0;
  logic [23:0] rr_wr_rid = '0;
  logic        rr_serialize = 1'b0;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [23:0] ins_rid = '0;
  logic [48:0] ins_vpn = '0;
  logic [35:0] ins_ppn = '0;
  logic        purge_valid = 1'b0;
  logic [23:0] purge_rid = '0;
  logic        lk_valid = 1'b0;
  logic [63:0] lk_vaddr = '0;
  logic        lk_hit;
  logic [47:0] lk_paddr;

  int n_chk = 0;
  int n_err = 0;

  // bench model
  logic        m_vld [NE];
  logic [23:0] m_rid [NE];
  logic [48:0] m_vpn [NE];
  logic [35:0] m_ppn [NE];
  int          m_ptr;
  logic [23:0] m_stage [8];
  logic [23:0] m_live  [8];

  always #2 clk = ~clk;

  rgn_tag_tlb dut_i (
    .clk(clk), .rst_n(rst_n),
    .rr_wr_en(rr_wr_en), .rr_wr_idx(rr_wr_idx), .rr_wr_rid(rr_wr_rid),
    .rr_serialize(rr_serialize),
    .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_rid(ins_rid), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn),
    .purge_valid(purge_valid), .purge_rid(purge_rid),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr)
  );

  function automatic logic [63:0] mk_va(input logic [2:0] r, input logic [48:0] v,
                                        input logic [11:0] o);
    return {r, v, o};
  endfunction

  function automatic logic [63:0] exp_pa(input logic [35:0] p, input logic [11:0] o);
    return {15'd0, 1'b1, p, o};
  endfunction

  function automatic int m_find(input logic [23:0] r, input logic [48:0] v);
    for (int i = 0; i < NE; i++)
      if (m_vld[i] && m_rid[i] == r && m_vpn[i] == v) return i;
    return -1;
  endfunction

  function automatic logic [63:0] m_lookup(input logic lv, input logic [63:0] a);
    int k;
    if (!lv) return 64'd0;
    k = m_find(m_live[a[63:61]], a[60:12]);
    if (k < 0) return 64'd0;
    return exp_pa(m_ppn[k], a[11:0]);
  endfunction

  task automatic m_reset();
    for (int i = 0; i < NE; i++) begin
      m_vld[i] = 1'b0; m_rid[i] = '0; m_vpn[i] = '0; m_ppn[i] = '0;
    end
    for (int i = 0; i < 8; i++) begin m_stage[i] = '0; m_live[i] = '0; end
    m_ptr = 0;
  endtask

  task automatic m_insert(input logic [23:0] r, input logic [48:0] v, input logic [35:0] p);
    int k;
    k = m_find(r, v);
    if (k < 0) for (int i = NE - 1; i >= 0; i--) if (!m_vld[i]) k = i;
    if (k < 0) begin k = m_ptr; m_ptr = (m_ptr + 1) % NE; end
    m_vld[k] = 1'b1; m_rid[k] = r; m_vpn[k] = v; m_ppn[k] = p;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    rr_wr_en = 0; rr_serialize = 0; ins_valid = 0; purge_valid = 0; lk_valid = 0;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one clock cycle with any mix of operations; lookup checked against the model
  task automatic cyc(input logic wr, input logic [2:0] widx, input logic [23:0] wd,
                     input logic ser,
                     input logic ins, input logic [23:0] irid, input logic [48:0] ivpn,
                     input logic [35:0] ippn,
                     input logic pur, input logic [23:0] prid,
                     input logic lkv, input logic [63:0] la, input string req);
    logic [23:0] snap [8];
    @(negedge clk);
    rr_wr_en = wr; rr_wr_idx = widx; rr_wr_rid = wd; rr_serialize = ser;
    ins_valid = ins; ins_rid = irid; ins_vpn = ivpn; ins_ppn = ippn;
    purge_valid = pur; purge_rid = prid;
    lk_valid = lkv; lk_vaddr = la;
    #1;
    chk(req, {15'd0, lk_hit, lk_paddr}, m_lookup(lkv, la));
    chk("R9 ready", {63'd0, ins_ready}, {63'd0, !pur});
    @(posedge clk);
    for (int i = 0; i < 8; i++) snap[i] = m_stage[i];
    if (wr) m_stage[widx] = wd;
    if (ser) for (int i = 0; i < 8; i++) m_live[i] = snap[i];
    if (pur) for (int i = 0; i < NE; i++) if (m_vld[i] && m_rid[i] == prid) m_vld[i] = 1'b0;
    if (ins && !pur) m_insert(irid, ivpn, ippn);
  endtask

  task automatic rr_wr(input logic [2:0] i, input logic [23:0] d, input logic ser);
    cyc(1, i, d, ser, 0, 0, 0, 0, 0, 0, 0, 0, "R4 write");
  endtask

  task automatic rr_ser();
    cyc(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R4 serialize");
  endtask

  task automatic ins(input logic [23:0] r, input logic [48:0] v, input logic [35:0] p);
    cyc(0, 0, 0, 0, 1, r, v, p, 0, 0, 0, 0, "R6 insert");
  endtask

  task automatic purge(input logic [23:0] r);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, r, 0, 0, "R8 purge");
  endtask

  // idle cycle with a lookup compared against an explicit expectation
  task automatic look(input string req, input logic lv, input logic [63:0] a,
                      input logic [63:0] exp);
    @(negedge clk);
    rr_wr_en = 0; rr_serialize = 0; ins_valid = 0; purge_valid = 0;
    lk_valid = lv; lk_vaddr = a;
    #1;
    chk(req, {15'd0, lk_hit, lk_paddr}, exp);
    @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();

    // R1: empty after reset, region registers zero
    look("R1 empty", 1, 64'h0000_0000_00A0_0123, 64'd0);
    look("R1 empty", 1, 64'hE000_0000_0000_0000, 64'd0);
    @(negedge clk); #1;
    chk("R1 ready", {63'd0, ins_ready}, 64'd1);
    ins(24'd0, 49'd5, 36'h77);
    look("R1 rid zero", 1, mk_va(3'd6, 49'd5, 12'h01f), exp_pa(36'h77, 12'h01f));

    // R4 and R2: staged write not live until serialize
    rr_wr(3'd2, 24'hB, 0);
    ins(24'hB, 49'hA00, 36'h123);
    look("R4 staged", 1, 64'h4000_0000_00A0_0ABC, 64'd0);
    rr_ser();
    look("R2 translate", 1, 64'h4000_0000_00A0_0ABC, exp_pa(36'h123, 12'hABC));
    // R4: write alongside serialize stays staged
    rr_wr(3'd3, 24'hB, 1);
    look("R4 same cycle", 1, 64'h6000_0000_00A0_0ABC, 64'd0);
    rr_ser();
    look("R3 alias rgn3", 1, 64'h6000_0000_00A0_0ABC, exp_pa(36'h123, 12'hABC));
    // R3: another region holding the same identifier
    rr_wr(3'd5, 24'hB, 0); rr_ser();
    look("R3 alias rgn5", 1, 64'hA000_0000_00A0_0ABC, exp_pa(36'h123, 12'hABC));
    // R5: swap identifier away and back
    rr_wr(3'd2, 24'hC, 0); rr_ser();
    look("R5 swapped out", 1, 64'h4000_0000_00A0_0ABC, 64'd0);
    rr_wr(3'd2, 24'hB, 0); rr_ser();
    look("R5 restored", 1, 64'h4000_0000_00A0_0ABC, exp_pa(36'h123, 12'hABC));
    // R6: overwrite in place
    ins(24'hB, 49'hA00, 36'h456);
    look("R6 overwrite", 1, 64'hA000_0000_00A0_0ABC, exp_pa(36'h456, 12'hABC));
    // R8: purge one identifier, keep another
    ins(24'hC, 49'hA00, 36'h999);
    rr_wr(3'd4, 24'hC, 0); rr_ser();
    purge(24'hB);
    look("R8 purged rgn5", 1, 64'hA000_0000_00A0_0ABC, 64'd0);
    look("R8 purged rgn2", 1, 64'h4000_0000_00A0_0ABC, 64'd0);
    look("R8 other kept", 1, 64'h8000_0000_00A0_0ABC, exp_pa(36'h999, 12'hABC));
    // R9: insert during purge is not taken
    cyc(0, 0, 0, 0, 1, 24'hC, 49'd7, 36'h1, 1, 24'hC, 0, 0, "R9 collide");
    look("R9 insert dropped", 1, mk_va(3'd4, 49'd7, 12'h0), 64'd0);
    look("R9 purge applied", 1, 64'h8000_0000_00A0_0ABC, 64'd0);
    // R10: lookup disabled
    ins(24'hC, 49'd8, 36'h55);
    look("R10 lk_valid low", 0, mk_va(3'd4, 49'd8, 12'h3), 64'd0);
    look("R10 hit control", 1, mk_va(3'd4, 49'd8, 12'h3), exp_pa(36'h55, 12'h3));
    // R11: insert not visible in its own cycle
    cyc(0, 0, 0, 0, 1, 24'hC, 49'd9, 36'h66, 0, 0, 1, mk_va(3'd4, 49'd9, 12'h4), "R11 same cycle");
    look("R11 next cycle", 1, mk_va(3'd4, 49'd9, 12'h4), exp_pa(36'h66, 12'h4));

    // R7: fill then round-robin replacement
    do_reset();
    rr_wr(3'd0, 24'd1, 0); rr_ser();
    for (int i = 0; i < NE; i++) ins(24'd1, 49'(i), 36'(256 + i));
    look("R7 full keeps 0", 1, mk_va(3'd0, 49'd0, 12'h1), exp_pa(36'd256, 12'h1));
    look("R7 full keeps 15", 1, mk_va(3'd0, 49'd15, 12'h1), exp_pa(36'd271, 12'h1));
    ins(24'd1, 49'd100, 36'hAAA);
    look("R7 evict slot0", 1, mk_va(3'd0, 49'd0, 12'h1), 64'd0);
    look("R7 slot1 kept", 1, mk_va(3'd0, 49'd1, 12'h1), exp_pa(36'd257, 12'h1));
    look("R7 new present", 1, mk_va(3'd0, 49'd100, 12'h1), exp_pa(36'hAAA, 12'h1));
    ins(24'd1, 49'd101, 36'hBBB);
    look("R7 evict slot1", 1, mk_va(3'd0, 49'd1, 12'h1), 64'd0);
    look("R7 slot2 kept", 1, mk_va(3'd0, 49'd2, 12'h1), exp_pa(36'd258, 12'h1));

    // random mix against the model (R3 R6 R7 R8 R11)
    for (int n = 0; n < 4000; n++) begin
      int op;
      logic [63:0] la;
      la = mk_va(3'($urandom), 49'($urandom % 24), 12'($urandom));
      op = $urandom % 16;
      case (op)
        0, 1: cyc(1, 3'($urandom), 24'($urandom % 4), 0, 0, 0, 0, 0, 0, 0, 1, la, "R3 rnd");
        2:    cyc(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 1, la, "R4 rnd");
        3:    cyc(1, 3'($urandom), 24'($urandom % 4), 1, 0, 0, 0, 0, 0, 0, 1, la, "R4 rnd");
        10:   cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 24'($urandom % 4), 1, la, "R8 rnd");
        11:   cyc(0, 0, 0, 0, 1, 24'($urandom % 4), 49'($urandom % 24), 36'($urandom),
                  1, 24'($urandom % 4), 1, la, "R9 rnd");
        12, 13: cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1'($urandom), la, "R10 rnd");
        default: cyc(0, 0, 0, 0, 1, 24'($urandom % 4), 49'($urandom % 24), 36'($urandom),
                     0, 0, 1, la, "R7 rnd");
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule